// File: doc/BRIEF.md
# Multi-Channel Event Timer

The block is an event timer that software sees as a bank of 64-bit registers on a simple synchronous bus. A single up-counting main counter advances by one every clock while a global run bit is set. It never counts down and never stops on its own. Several compare channels watch the counter. Each channel has its own interrupt line.

Each channel has a comparator that software loads with the counter value at which an event should occur. By default the channel works as a one-shot match, and hardware never changes the comparator. A channel built with periodic support can instead add a stored period to its comparator on every match, which gives a steady train of events. A value-set control lets one comparator write load both the first match point and the period.

A narrow mode compares only the low 32 bits of the counter. In that mode the channel also fires when those 32 bits roll over.

Each match sets a sticky status bit, even when the channel's interrupt is masked. Software clears a status bit by writing one to it. The interrupt line is the status bit gated by the channel's interrupt enable.

Top module: `evtimer_top`

## Requirements
- R1: After reset, the main counter reads 0 and the run bit is 0. While the run bit (bit 0 at address 0x01) is 1, the counter rises by exactly one per clock. While the run bit is 0, the counter holds its value.
- R2: A write to the counter register at address 0x03 loads the counter only while the run bit is 0. The same write made while the counter runs has no effect.
- R3: The read-only capability register at address 0x00 returns the following fields:
  - bits [7:0]: the channel count.
  - bit 8: set to 1, meaning the counter is 64 bits wide.
  - bits [63:32]: the counter tick period in femtoseconds.
- R4: One-shot mode:
  - A channel fires on the clock after the counter equals its comparator. Its status bit is visible one clock after that match.
  - The channel fires once per match value, and hardware leaves the comparator unchanged.
- R5: When channel config bit 5 is set, only the low 32 bits of the counter and the comparator are compared. In this mode the channel also fires on the clock where the low 32 bits wrap from all ones to zero.
- R6: Periodic mode:
  - Channel config bit 3 requests periodic mode. Read-only bit 4 reports whether the channel supports it.
  - On a capable channel in periodic mode, each match adds the stored period to the comparator.
  - On a channel without the capability, bit 3 reads 0 and the comparator is never changed by hardware.
- R7: Channel config bit 6 is the value-set control. While it is set, the next comparator write loads both the comparator and the period, and bit 6 then reads 0.
- R8: Status behaviour at address 0x02, where bit i belongs to channel i:
  - A bit is set on every match, even when the interrupt enable is 0.
  - Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
  - A set bit stays set when further matches arrive.
- R9: Interrupt output i is high exactly while status bit i and channel config bit 2 (interrupt enable) are both 1. Each channel drives only its own line.
- R10: Read data appears on the clock after a read strobe. Channel i's config register is at 0x10+2i and its comparator is at 0x11+2i. Unmapped addresses, such as 0x0F, read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| irq | output | NUM_CH | Per-channel level interrupts |

## Verification
A corrupted counter shows up in a read of the counter register, two clocks after the damage. It also shows up as an interrupt edge that lands in the wrong clock, because every match time in the bench is predicted to the exact cycle. A comparator that hardware corrupts, or a lost period, appears as a shifted second interrupt edge or as a wrong comparator read one clock after the read strobe. A status bit that clears by itself, or that a zero write clears, drops its interrupt line at the next clock edge.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;
    // Register word addresses
    localparam int unsigned ADDR_CAPS  = 0;
    localparam int unsigned ADDR_GCFG  = 1;
    localparam int unsigned ADDR_STAT  = 2;
    localparam int unsigned ADDR_COUNT = 3;
    localparam int unsigned CH_BASE    = 16;
    localparam int unsigned CH_STRIDE  = 2;

    // Channel configuration bit positions
    localparam int unsigned CFG_IEN  = 2;
    localparam int unsigned CFG_PER  = 3;
    localparam int unsigned CFG_PCAP = 4;
    localparam int unsigned CFG_M32  = 5;
    localparam int unsigned CFG_VSET = 6;

    // Width of the narrow compare mode
    localparam int unsigned LO_W = 32;
endpackage

// File: rtl/evtimer_counter.sv
module evtimer_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (run) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (ld) begin
            s_d.cnt = ld_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/evtimer_channel.sv
module evtimer_channel
    import evtimer_pkg::*;
#(
    parameter int unsigned CNT_W  = 64,
    parameter bit          PER_OK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cfg_we,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             sts_clr,
    output logic [CNT_W-1:0] cfg_rd,
    output logic [CNT_W-1:0] cmp_o,
    output logic             per_eff,
    output logic             sts,
    output logic             irq
);
    typedef struct packed {
        logic             ien;
        logic             per;
        logic             m32;
        logic             vset;
        logic             sts;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] period;
    } ch_st_t;

    ch_st_t s_d, s_q;
    logic   match, wrap, fire;

    always_comb begin
        match = s_q.m32 ? (cnt[LO_W-1:0] == s_q.cmp[LO_W-1:0]) : (cnt == s_q.cmp);
        wrap  = s_q.m32 && (&cnt[LO_W-1:0]);
        fire  = run && (match || wrap);

        s_d = s_q;
        if (cfg_we) begin
            s_d.ien  = wdata[CFG_IEN];
            s_d.per  = wdata[CFG_PER] & PER_OK;
            s_d.m32  = wdata[CFG_M32];
            s_d.vset = wdata[CFG_VSET];
        end
        if (cmp_we) begin
            s_d.cmp = wdata;
            if (s_q.vset) begin
                s_d.period = wdata;
                s_d.vset   = 1'b0;
            end
        end else if (run && match && s_q.per) begin
            s_d.cmp = s_q.cmp + s_q.period;
        end
        s_d.sts = (s_q.sts & ~sts_clr) | fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        cfg_rd           = '0;
        cfg_rd[CFG_IEN]  = s_q.ien;
        cfg_rd[CFG_PER]  = s_q.per;
        cfg_rd[CFG_PCAP] = PER_OK;
        cfg_rd[CFG_M32]  = s_q.m32;
        cfg_rd[CFG_VSET] = s_q.vset;
    end

    assign cmp_o   = s_q.cmp;
    assign per_eff = s_q.per;
    assign sts     = s_q.sts;
    assign irq     = s_q.sts & s_q.ien;
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
    import evtimer_pkg::*;
#(
    parameter int unsigned       NUM_CH  = 3,
    parameter int unsigned       CNT_W   = 64,
    parameter int unsigned       ADDR_W  = 8,
    parameter int unsigned       TICK_FS = 32'd10_000_000,
    parameter logic [NUM_CH-1:0] PER_CAP = {1'b0, {(NUM_CH-1){1'b1}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] rdata;
    } top_st_t;

    top_st_t s_d, s_q;

    logic              gen_en;
    logic [CNT_W-1:0]  cnt_q;
    logic              cnt_ld;
    logic              stat_we;
    logic [NUM_CH-1:0] sts_v;
    logic [NUM_CH-1:0] per_v;
    logic [CNT_W-1:0]  cfg_v [NUM_CH];
    logic [CNT_W-1:0]  cmp_v [NUM_CH];
    logic [CNT_W-1:0]  caps;
    logic [CNT_W-1:0]  rd_mux;

    assign gen_en  = s_q.en;
    assign stat_we = bus_we && (bus_addr == ADDR_W'(ADDR_STAT));
    assign cnt_ld  = bus_we && (bus_addr == ADDR_W'(ADDR_COUNT)) && !s_q.en;

    evtimer_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (s_q.en),
        .ld     (cnt_ld),
        .ld_val (bus_wdata),
        .cnt    (cnt_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int unsigned CFG_A = CH_BASE + CH_STRIDE * i;
        logic cfg_we, cmp_we;
        assign cfg_we = bus_we && (bus_addr == ADDR_W'(CFG_A));
        assign cmp_we = bus_we && (bus_addr == ADDR_W'(CFG_A + 1));

        evtimer_channel #(.CNT_W(CNT_W), .PER_OK(PER_CAP[i])) ch_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (s_q.en),
            .cnt     (cnt_q),
            .cfg_we  (cfg_we),
            .cmp_we  (cmp_we),
            .wdata   (bus_wdata),
            .sts_clr (stat_we && bus_wdata[i]),
            .cfg_rd  (cfg_v[i]),
            .cmp_o   (cmp_v[i]),
            .per_eff (per_v[i]),
            .sts     (sts_v[i]),
            .irq     (irq[i])
        );
    end

    always_comb begin
        caps         = '0;
        caps[7:0]    = 8'(NUM_CH);
        caps[8]      = 1'b1;
        caps[63:32]  = TICK_FS;
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(ADDR_CAPS))  rd_mux = caps;
        if (bus_addr == ADDR_W'(ADDR_GCFG))  rd_mux[0] = s_q.en;
        if (bus_addr == ADDR_W'(ADDR_STAT))  rd_mux[NUM_CH-1:0] = sts_v;
        if (bus_addr == ADDR_W'(ADDR_COUNT)) rd_mux = cnt_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i))     rd_mux = cfg_v[i];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + 1)) rd_mux = cmp_v[i];
        end
    end

    always_comb begin
        s_d = s_q;
        if (bus_we && (bus_addr == ADDR_W'(ADDR_GCFG))) s_d.en = bus_wdata[0];
        if (bus_re) s_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk
    import evtimer_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_CH-1:0] stat_wdata,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic [NUM_CH-1:0] irq,
    input logic              gen_en,
    input logic [CNT_W-1:0]  cnt,
    input logic [NUM_CH-1:0] sts,
    input logic [NUM_CH-1:0] per_eff,
    input logic [CNT_W-1:0]  cmp_all [NUM_CH]
);
    logic              cnt_wr;
    logic [NUM_CH-1:0] clr_mask;

    assign cnt_wr   = bus_we && (bus_addr == ADDR_W'(ADDR_COUNT));
    assign clr_mask = (bus_we && (bus_addr == ADDR_W'(ADDR_STAT))) ? stat_wdata : '0;

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gen_en) |-> cnt == $past(cnt) + 1'b1);

    // R1
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(gen_en) && !$past(cnt_wr)) |-> $stable(cnt));

    // R8
    sticky_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sts) & ~$past(clr_mask)) & ~sts) == '0);

    // R9
    irq_needs_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~sts) == '0);

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_re) && $past(bus_addr) == ADDR_W'(15)) |-> bus_rdata == '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
        logic cmp_wr;
        assign cmp_wr = bus_we && (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + 1));
        // R4
        oneshot_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!per_eff[i] && !cmp_wr) |=> $stable(cmp_all[i]));
    end
endmodule

bind evtimer_top evtimer_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_addr   (bus_addr),
    .stat_wdata (bus_wdata[NUM_CH-1:0]),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .gen_en     (gen_en),
    .cnt        (cnt_q),
    .sts        (sts_v),
    .per_eff    (per_v),
    .cmp_all    (cmp_v)
);

// File: tb/evtimer_tb.sv
`timescale 1ns/1ps
module evtimer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    evtimer_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic [15:0] req;
        logic        rd;
        logic [7:0]  addr;
        logic [63:0] data;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{"R3",  1'b1, 8'h00, 64'h0098_9680_0000_0103},
        '{"R2",  1'b0, 8'h03, 64'd100},
        '{"R2",  1'b1, 8'h03, 64'd100},
        '{"R6",  1'b0, 8'h14, 64'h7C},
        '{"R6",  1'b1, 8'h14, 64'h64},
        '{"R7",  1'b0, 8'h15, 64'h55},
        '{"R7",  1'b1, 8'h14, 64'h24},
        '{"R6",  1'b0, 8'h10, 64'h08},
        '{"R6",  1'b1, 8'h10, 64'h18},
        '{"R4",  1'b0, 8'h13, 64'h1234},
        '{"R4",  1'b1, 8'h13, 64'h1234},
        '{"R10", 1'b1, 8'h0F, 64'h0},
        '{"R8",  1'b1, 8'h02, 64'h0}
    };

    task automatic check(input logic [23:0] req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] r, r2;
        do_reset();

        // Reset state (R1)
        check("R9", {61'd0, irq}, 64'd0);
        bus_read(8'h03, r); check("R1", r, 64'd0);
        bus_read(8'h01, r); check("R1", r, 64'd0);

        // Register-bank vector table
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].rd) begin
                bus_read(VEC[k].addr, r);
                check({8'h20, VEC[k].req}, r, VEC[k].data);
            end else begin
                bus_write(VEC[k].addr, VEC[k].data);
            end
        end

        // Counter run, ignored load, hold (R1, R2)
        do_reset();
        bus_write(8'h03, 64'd50);
        bus_write(8'h01, 64'd1);
        bus_read(8'h03, r);  check("R1", r, 64'd51);
        bus_read(8'h03, r2); check("R1", r2, r + 64'd2);
        bus_write(8'h03, 64'd7);
        bus_read(8'h03, r);  check("R2", r, r2 + 64'd4);
        bus_write(8'h01, 64'd0);
        bus_read(8'h03, r);
        repeat (5) @(negedge clk);
        bus_read(8'h03, r2); check("R1", r2, r);

        // One-shot, W1C, masked status (R4, R8, R9)
        do_reset();
        bus_write(8'h12, 64'h04);
        bus_write(8'h13, 64'd20);
        bus_write(8'h15, 64'd25);
        bus_write(8'h01, 64'd1);
        repeat (20) @(negedge clk);
        check("R4", {63'd0, irq[1]}, 64'd0);
        @(negedge clk);
        check("R4", {63'd0, irq[1]}, 64'd1);
        bus_write(8'h02, 64'd0);
        check("R8", {63'd0, irq[1]}, 64'd1);
        bus_write(8'h02, 64'd2);
        check("R8", {63'd0, irq[1]}, 64'd0);
        bus_read(8'h13, r); check("R4", r, 64'd20);
        repeat (30) @(negedge clk);
        check("R4", {61'd0, irq}, 64'd0);
        bus_read(8'h02, r); check("R8", r, 64'd5);
        bus_write(8'h14, 64'h04);
        check("R9", {61'd0, irq}, 64'd4);

        // Periodic reload and value-set (R6, R7)
        do_reset();
        bus_write(8'h10, 64'h4C);
        bus_write(8'h11, 64'd10);
        bus_read(8'h10, r); check("R7", r, 64'h1C);
        bus_write(8'h14, 64'h0C);
        bus_write(8'h15, 64'd5);
        bus_write(8'h01, 64'd1);
        repeat (12) @(negedge clk);
        check("R6", {63'd0, irq[0]}, 64'd1);
        bus_write(8'h02, 64'd1);
        check("R8", {63'd0, irq[0]}, 64'd0);
        repeat (6) @(negedge clk);
        check("R6", {63'd0, irq[0]}, 64'd0);
        @(negedge clk);
        check("R6", {63'd0, irq[0]}, 64'd1);
        bus_read(8'h11, r); check("R7", r, 64'd30);
        bus_read(8'h15, r); check("R6", r, 64'd5);
        bus_read(8'h02, r); check("R8", r, 64'd7);

        // Narrow compare with wrap event (R5)
        do_reset();
        bus_write(8'h03, 64'hFFFF_FFF0);
        bus_write(8'h12, 64'h24);
        bus_write(8'h13, 64'h1_0000_0003);
        bus_write(8'h01, 64'd1);
        repeat (15) @(negedge clk);
        check("R5", {63'd0, irq[1]}, 64'd0);
        @(negedge clk);
        check("R5", {63'd0, irq[1]}, 64'd1);
        bus_write(8'h02, 64'd2);
        check("R5", {63'd0, irq[1]}, 64'd0);
        @(negedge clk);
        check("R5", {63'd0, irq[1]}, 64'd0);
        @(negedge clk);
        check("R5", {63'd0, irq[1]}, 64'd1);

        // Reset while active (R1)
        do_reset();
        check("R9", {61'd0, irq}, 64'd0);
        bus_read(8'h03, r); check("R1", r, 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule